// File: doc/BRIEF.md
# Data Space Address Generator

This block turns the addressing fields of a load or store into one effective data-space address and steers the access to one of three regions. The regions are the general-purpose registers, the I/O registers and the internal SRAM. It holds three 16-bit pointers, named X, Y and Z. For each access the address comes from one of these sources:

- a full direct address;
- a pointer used as it stands;
- the Y or Z pointer plus a 6-bit displacement;
- a pointer that is decremented before use;
- a pointer that is incremented after use.

The pointer update is written back only when the access completes. An aborted access therefore leaves every pointer as it was.

Every accepted access runs in two clock cycles. In the first cycle the address, the region select and the local offset are valid, and `busy` is high so that the core can stall. In the second cycle the read or write strobe fires and read data is returned from the selected region. An address beyond the SRAM selects no region and raises an out-of-range flag. A disallowed mode or pointer combination raises a mode-error flag. In both of these cases no strobe is issued.

Top module: `dataAddrGen`

## Requirements
- R1: While reset is held and after it is released, `busy`, `memRd`, `memWr`, `regSel`, `ioSel`, `sramSel`, `outOfRange` and `modeErr` are 0, and all three pointers read 0x0000.
- R2: With `accMode`=0 (direct), the effective address equals `directAddr`, over the whole 16-bit range.
- R3: With `accMode`=2 (displacement), the address is the Y pointer (`ptrSel`=1) or the Z pointer (`ptrSel`=2) plus `disp` (0 to 63), wrapping modulo 2^16, and the pointer is not changed. With `ptrSel`=0 (X) in this mode, with `ptrSel`=3 in any pointer mode, or with an `accMode` of 5 to 7, `modeErr` is 1 in both cycles, no region select is raised, no strobe fires and no pointer changes.
- R4: With `accMode`=3 (pre-decrement), the address is the selected pointer minus 1 and the pointer takes that value when the access completes, so that 0x0000 wraps to 0xFFFF.
- R5: With `accMode`=4 (post-increment), the address is the selected pointer and the pointer becomes that value plus 1 when the access completes, so that 0xFFFF wraps to 0x0000. With `accMode`=1 (plain indirect), the address is the selected pointer and the pointer is unchanged.
- R6: Addresses 0x0000 to 0x001F raise `regSel` only, with `localOff` equal to the address.
- R7: Addresses 0x0020 to 0x005F raise `ioSel` only, with `localOff` equal to the address minus 0x20.
- R8: Addresses 0x0060 to 0x015F raise `sramSel` only, with `localOff` equal to the address minus 0x60.
- R9: Addresses above 0x015F raise `outOfRange` with no region select and no strobe. A write there is dropped and a read returns 0x00 on `rdData`.
- R10: A request is taken only when the block is idle. In the first cycle after it is taken, `busy` is 1 and both strobes are 0. In the second cycle `busy` is 0 and exactly the requested strobe is 1. The block is then idle, and a request held through the access is not taken again during it. When `rdReq` and `wrReq` are both high, the access is a read.
- R11: `abortIn` high in either cycle of an access ends it at the next edge. No strobe fires in that cycle or later, and the pointer is not updated.
- R12: `ptrWrEn` loads `ptrWrData` into the pointer chosen by `ptrWrSel` (0 X, 1 Y, 2 Z) only while idle. A load presented during an access is ignored.
- R13: In the second cycle of a read, `rdData` carries `regRdData`, `ioRdData` or `sramRdData` according to the decoded region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accMode | input | 3 | Addressing mode: 0 direct, 1 indirect, 2 displacement, 3 pre-decrement, 4 post-increment |
| ptrSel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| directAddr | input | 16 | Full address for direct mode |
| disp | input | 6 | Displacement added in displacement mode |
| rdReq | input | 1 | Read request |
| wrReq | input | 1 | Write request |
| abortIn | input | 1 | Cancels the access in progress |
| ptrWrEn | input | 1 | Pointer load enable |
| ptrWrSel | input | 2 | Pointer chosen for a load |
| ptrWrData | input | 16 | Value to load into the pointer |
| regRdData | input | 8 | Read data from the register file |
| ioRdData | input | 8 | Read data from the I/O registers |
| sramRdData | input | 8 | Read data from the SRAM |
| effAddr | output | 16 | Captured effective address |
| localOff | output | 8 | Offset inside the selected region |
| regSel | output | 1 | Register file selected |
| ioSel | output | 1 | I/O registers selected |
| sramSel | output | 1 | SRAM selected |
| outOfRange | output | 1 | Address lies beyond the SRAM |
| modeErr | output | 1 | Disallowed mode or pointer combination |
| busy | output | 1 | First cycle of an access |
| memRd | output | 1 | Read strobe, second cycle |
| memWr | output | 1 | Write strobe, second cycle |
| rdData | output | 8 | Read data returned to the core |
| ptrX | output | 16 | X pointer |
| ptrY | output | 16 | Y pointer |
| ptrZ | output | 16 | Z pointer |

## Verification
Direct addresses are placed on both edges of every region boundary (0x1F/0x20, 0x5F/0x60, 0x15F/0x160) and at 0xFFFF. These show that each decode comparison is strict in the right direction and that each offset subtraction uses the right base. Each pointer mode is run with a pointer value that lands in a different region, and with values that wrap at 0x0000 and 0xFFFF. This tells decrement-before-use from increment-after-use and shows whether the carry wraps. Aborts placed in each of the two cycles, loads presented during an access, and simultaneous read and write requests show whether the commit and the strobes are tied to the second cycle alone.

// File: rtl/dagPkg.sv
package dagPkg;

  localparam logic [2:0] MODE_DIRECT  = 3'd0;
  localparam logic [2:0] MODE_IND     = 3'd1;
  localparam logic [2:0] MODE_DISP    = 3'd2;
  localparam logic [2:0] MODE_PREDEC  = 3'd3;
  localparam logic [2:0] MODE_POSTINC = 3'd4;

  localparam logic [1:0] PTR_X    = 2'd0;
  localparam logic [1:0] PTR_Y    = 2'd1;
  localparam logic [1:0] PTR_Z    = 2'd2;
  localparam logic [1:0] PTR_NONE = 2'd3;

  localparam int NUM_PTR = 3;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;  // latch the computed address and request
    logic active;   // an access is in either cycle
    logic strobe;   // second cycle, not aborted: fire the memory strobe
    logic commit;   // end of the second cycle, not aborted: write the pointer back
    logic loadOk;   // idle: pointer loads allowed
  } ctrlStrobes_t;

endpackage

// File: rtl/dagControl.sv
module dagControl
  import dagPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdReq,
  input  logic         wrReq,
  input  logic         abortIn,
  output ctrlStrobes_t ctrl,
  output logic         busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_XFER} seqState_e;

  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (rdReq || wrReq) stateNext = ST_ADDR;
      ST_ADDR: stateNext = abortIn ? ST_IDLE : ST_XFER;
      ST_XFER: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl.capture = (state == ST_IDLE) && (rdReq || wrReq);
    ctrl.active  = (state != ST_IDLE);
    ctrl.strobe  = (state == ST_XFER) && !abortIn;
    ctrl.commit  = (state == ST_XFER) && !abortIn;
    ctrl.loadOk  = (state == ST_IDLE);
  end

  assign busy = (state == ST_ADDR);

endmodule

// File: rtl/dagDatapath.sv
module dagDatapath
  import dagPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 6,
  parameter int DATA_W     = 8,
  parameter int REG_COUNT  = 32,
  parameter int IO_COUNT   = 64,
  parameter int SRAM_BYTES = 256,
  localparam int OFF_W     = $clog2(SRAM_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       ctrl,
  input  logic [2:0]         accMode,
  input  logic [1:0]         ptrSel,
  input  logic [ADDR_W-1:0]  directAddr,
  input  logic [DISP_W-1:0]  disp,
  input  logic               rdReq,
  input  logic               wrReq,
  input  logic               ptrWrEn,
  input  logic [1:0]         ptrWrSel,
  input  logic [ADDR_W-1:0]  ptrWrData,
  input  logic [DATA_W-1:0]  regRdData,
  input  logic [DATA_W-1:0]  ioRdData,
  input  logic [DATA_W-1:0]  sramRdData,
  output logic [ADDR_W-1:0]  effAddr,
  output logic [OFF_W-1:0]   localOff,
  output logic               regSel,
  output logic               ioSel,
  output logic               sramSel,
  output logic               outOfRange,
  output logic               modeErr,
  output logic               memRd,
  output logic               memWr,
  output logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  ptrX,
  output logic [ADDR_W-1:0]  ptrY,
  output logic [ADDR_W-1:0]  ptrZ
);

  localparam int IO_BASE   = REG_COUNT;
  localparam int SRAM_BASE = REG_COUNT + IO_COUNT;
  localparam int SRAM_LAST = SRAM_BASE + SRAM_BYTES - 1;
  localparam logic [ADDR_W-1:0] IO_BASE_A   = IO_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SRAM_BASE_A = SRAM_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SRAM_LAST_A = SRAM_LAST[ADDR_W-1:0];

  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [ADDR_W-1:0] base, addrC, newPtrC, dispExt;
  logic              updC, errC, selOk;

  // captured access
  logic [ADDR_W-1:0] addrQ, newPtrQ;
  logic [1:0]        selQ;
  logic              updQ, errQ, wrQ;

  assign dispExt = {{(ADDR_W-DISP_W){1'b0}}, disp};
  assign selOk   = (ptrSel != PTR_NONE);

  always_comb begin
    case (ptrSel)
      PTR_X:   base = ptrQ[0];
      PTR_Y:   base = ptrQ[1];
      PTR_Z:   base = ptrQ[2];
      default: base = '0;
    endcase
  end

  always_comb begin
    addrC   = directAddr;
    newPtrC = base;
    updC    = 1'b0;
    errC    = 1'b0;
    case (accMode)
      MODE_DIRECT: ;
      MODE_IND: begin
        addrC = base;
        errC  = !selOk;
      end
      MODE_DISP: begin
        addrC = base + dispExt;
        errC  = !((ptrSel == PTR_Y) || (ptrSel == PTR_Z));
      end
      MODE_PREDEC: begin
        addrC   = base - ADDR_W'(1);
        newPtrC = base - ADDR_W'(1);
        updC    = selOk;
        errC    = !selOk;
      end
      MODE_POSTINC: begin
        addrC   = base;
        newPtrC = base + ADDR_W'(1);
        updC    = selOk;
        errC    = !selOk;
      end
      default: errC = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      newPtrQ <= '0;
      selQ    <= '0;
      updQ    <= 1'b0;
      errQ    <= 1'b0;
      wrQ     <= 1'b0;
    end else if (ctrl.capture) begin
      addrQ   <= addrC;
      newPtrQ <= newPtrC;
      selQ    <= ptrSel;
      updQ    <= updC;
      errQ    <= errC;
      wrQ     <= wrReq && !rdReq;
    end
  end

  // pointer registers: write-back at completion, loads only while idle
  for (genvar gi = 0; gi < NUM_PTR; gi++) begin : gPtr
    always_ff @(posedge clk) begin
      if (!rstN)
        ptrQ[gi] <= '0;
      else if (ctrl.commit && updQ && (selQ == 2'(gi)))
        ptrQ[gi] <= newPtrQ;
      else if (ctrl.loadOk && ptrWrEn && (ptrWrSel == 2'(gi)))
        ptrQ[gi] <= ptrWrData;
    end
  end

  logic okAcc;
  assign okAcc      = ctrl.active && !errQ;
  assign regSel     = okAcc && (addrQ < IO_BASE_A);
  assign ioSel      = okAcc && (addrQ >= IO_BASE_A) && (addrQ < SRAM_BASE_A);
  assign sramSel    = okAcc && (addrQ >= SRAM_BASE_A) && (addrQ <= SRAM_LAST_A);
  assign outOfRange = okAcc && (addrQ > SRAM_LAST_A);
  assign modeErr    = ctrl.active && errQ;
  assign effAddr    = addrQ;

  logic [ADDR_W-1:0] ioRel, sramRel;
  assign ioRel   = addrQ - IO_BASE_A;
  assign sramRel = addrQ - SRAM_BASE_A;

  always_comb begin
    if (regSel)       localOff = addrQ[OFF_W-1:0];
    else if (ioSel)   localOff = ioRel[OFF_W-1:0];
    else if (sramSel) localOff = sramRel[OFF_W-1:0];
    else              localOff = '0;
  end

  logic hit;
  assign hit   = regSel || ioSel || sramSel;
  assign memRd = ctrl.strobe && hit && !wrQ;
  assign memWr = ctrl.strobe && hit && wrQ;

  always_comb begin
    if (sramSel)     rdData = sramRdData;
    else if (ioSel)  rdData = ioRdData;
    else if (regSel) rdData = regRdData;
    else             rdData = '0;
  end

  assign ptrX = ptrQ[0];
  assign ptrY = ptrQ[1];
  assign ptrZ = ptrQ[2];

endmodule

// File: rtl/dataAddrGen.sv
module dataAddrGen
  import dagPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DISP_W     = 6,
  parameter int DATA_W     = 8,
  parameter int REG_COUNT  = 32,
  parameter int IO_COUNT   = 64,
  parameter int SRAM_BYTES = 256,
  localparam int OFF_W     = $clog2(SRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        accMode,
  input  logic [1:0]        ptrSel,
  input  logic [ADDR_W-1:0] directAddr,
  input  logic [DISP_W-1:0] disp,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              abortIn,
  input  logic              ptrWrEn,
  input  logic [1:0]        ptrWrSel,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] ioRdData,
  input  logic [DATA_W-1:0] sramRdData,
  output logic [ADDR_W-1:0] effAddr,
  output logic [OFF_W-1:0]  localOff,
  output logic              regSel,
  output logic              ioSel,
  output logic              sramSel,
  output logic              outOfRange,
  output logic              modeErr,
  output logic              busy,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ptrX,
  output logic [ADDR_W-1:0] ptrY,
  output logic [ADDR_W-1:0] ptrZ
);

  ctrlStrobes_t ctrl;

  dagControl uCtrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq),
    .abortIn(abortIn), .ctrl(ctrl), .busy(busy)
  );

  dagDatapath #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .DATA_W(DATA_W),
    .REG_COUNT(REG_COUNT), .IO_COUNT(IO_COUNT), .SRAM_BYTES(SRAM_BYTES)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .accMode(accMode), .ptrSel(ptrSel), .directAddr(directAddr), .disp(disp),
    .rdReq(rdReq), .wrReq(wrReq),
    .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
    .regRdData(regRdData), .ioRdData(ioRdData), .sramRdData(sramRdData),
    .effAddr(effAddr), .localOff(localOff),
    .regSel(regSel), .ioSel(ioSel), .sramSel(sramSel),
    .outOfRange(outOfRange), .modeErr(modeErr),
    .memRd(memRd), .memWr(memWr), .rdData(rdData),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ)
  );

endmodule

// File: rtl/dagChecker.sv
module dagChecker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memRd,
  input logic              memWr,
  input logic              regSel,
  input logic              ioSel,
  input logic              sramSel,
  input logic              outOfRange,
  input logic              modeErr,
  input logic              abortIn,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] ptrX,
  input logic [ADDR_W-1:0] ptrY,
  input logic [ADDR_W-1:0] ptrZ
);

  // R10: the first cycle is never followed by another first cycle
  assert_busy_one_cycle_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R10: a strobe only appears in the cycle after busy
  assert_strobe_after_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> $past(busy));

  // R10: never both strobes
  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R6 R7 R8 R9 R3: at most one decode outcome
  assert_region_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regSel, ioSel, sramSel, outOfRange, modeErr}));

  // R9: out-of-range access issues no strobe and reads zero
  assert_oor_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> (!memRd && !memWr && (rdData == '0)));

  // R3: mode error issues no strobe
  assert_moderr_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> (!memRd && !memWr));

  // R11: abort in the first cycle suppresses the following strobe
  assert_abort_nostrobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abortIn) |=> (!memRd && !memWr));

  // R12: pointers hold across the first-cycle edge
  assert_ptr_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({ptrX, ptrY, ptrZ}));

endmodule

bind dataAddrGen dagChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .memRd(memRd), .memWr(memWr),
  .regSel(regSel), .ioSel(ioSel), .sramSel(sramSel),
  .outOfRange(outOfRange), .modeErr(modeErr), .abortIn(abortIn),
  .rdData(rdData), .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ)
);

// File: tb/tb_dataAddrGen.sv
`timescale 1ns/100ps
module tb_dataAddrGen;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  accMode;
  logic [1:0]  ptrSel;
  logic [15:0] directAddr;
  logic [5:0]  disp;
  logic        rdReq, wrReq, abortIn, ptrWrEn;
  logic [1:0]  ptrWrSel;
  logic [15:0] ptrWrData;
  logic [7:0]  regRdData, ioRdData, sramRdData;
  logic [15:0] effAddr;
  logic [7:0]  localOff;
  logic        regSel, ioSel, sramSel, outOfRange, modeErr, busy, memRd, memWr;
  logic [7:0]  rdData;
  logic [15:0] ptrX, ptrY, ptrZ;

  always #2.5 clk = ~clk;

  dataAddrGen dut (
    .clk(clk), .rstN(rstN), .accMode(accMode), .ptrSel(ptrSel),
    .directAddr(directAddr), .disp(disp), .rdReq(rdReq), .wrReq(wrReq),
    .abortIn(abortIn), .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
    .regRdData(regRdData), .ioRdData(ioRdData), .sramRdData(sramRdData),
    .effAddr(effAddr), .localOff(localOff), .regSel(regSel), .ioSel(ioSel),
    .sramSel(sramSel), .outOfRange(outOfRange), .modeErr(modeErr), .busy(busy),
    .memRd(memRd), .memWr(memWr), .rdData(rdData),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // region code: 0 reg, 1 io, 2 sram, 3 none
  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  sel;
    logic [15:0] dAddr;
    logic [5:0]  dsp;
    logic [15:0] ptrInit;
    logic        wr;
    logic [15:0] expAddr;
    logic [1:0]  expReg;
    logic [7:0]  expOff;
    logic [15:0] expPtr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd3, 16'h0005, 6'd0,  16'h0000, 1'b0, 16'h0005, 2'd0, 8'h05, 16'h0000},
    '{3'd0, 2'd3, 16'h001F, 6'd0,  16'h0000, 1'b1, 16'h001F, 2'd0, 8'h1F, 16'h0000},
    '{3'd0, 2'd3, 16'h0020, 6'd0,  16'h0000, 1'b0, 16'h0020, 2'd1, 8'h00, 16'h0000},
    '{3'd0, 2'd3, 16'h005F, 6'd0,  16'h0000, 1'b1, 16'h005F, 2'd1, 8'h3F, 16'h0000},
    '{3'd0, 2'd3, 16'h0060, 6'd0,  16'h0000, 1'b0, 16'h0060, 2'd2, 8'h00, 16'h0000},
    '{3'd0, 2'd3, 16'h015F, 6'd0,  16'h0000, 1'b1, 16'h015F, 2'd2, 8'hFF, 16'h0000},
    '{3'd0, 2'd3, 16'h0160, 6'd0,  16'h0000, 1'b0, 16'h0160, 2'd3, 8'h00, 16'h0000},
    '{3'd0, 2'd3, 16'hFFFF, 6'd0,  16'h0000, 1'b1, 16'hFFFF, 2'd3, 8'h00, 16'h0000},
    '{3'd1, 2'd0, 16'h0000, 6'd0,  16'h0042, 1'b0, 16'h0042, 2'd1, 8'h22, 16'h0042},
    '{3'd2, 2'd1, 16'h0000, 6'd63, 16'h0100, 1'b0, 16'h013F, 2'd2, 8'hDF, 16'h0100},
    '{3'd2, 2'd2, 16'h0000, 6'd63, 16'hFFF0, 1'b1, 16'h002F, 2'd1, 8'h0F, 16'hFFF0},
    '{3'd3, 2'd0, 16'h0000, 6'd0,  16'h0061, 1'b0, 16'h0060, 2'd2, 8'h00, 16'h0060},
    '{3'd3, 2'd2, 16'h0000, 6'd0,  16'h0000, 1'b1, 16'hFFFF, 2'd3, 8'h00, 16'hFFFF},
    '{3'd4, 2'd1, 16'h0000, 6'd0,  16'h015F, 1'b1, 16'h015F, 2'd2, 8'hFF, 16'h0160},
    '{3'd4, 2'd0, 16'h0000, 6'd0,  16'hFFFF, 1'b0, 16'hFFFF, 2'd3, 8'h00, 16'h0000},
    '{3'd2, 2'd1, 16'h0000, 6'd0,  16'h0000, 1'b0, 16'h0000, 2'd0, 8'h00, 16'h0000}
  };

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string regTag(input logic [1:0] r);
    case (r)
      2'd0:    return "R6";
      2'd1:    return "R7";
      2'd2:    return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] getPtr(input logic [1:0] s);
    case (s)
      2'd0:    return ptrX;
      2'd1:    return ptrY;
      default: return ptrZ;
    endcase
  endfunction

  // snapshots
  logic        t1Busy, t1Err, t2Busy, t2Rd, t2Wr, n3Busy;
  logic [15:0] t1Addr;
  logic [3:0]  t1Sel;
  logic [7:0]  t1Off, t2Data;
  logic [1:0]  t1Strb;

  task automatic loadPtr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    ptrWrEn = 1'b1; ptrWrSel = s; ptrWrData = v;
    @(negedge clk);
    ptrWrEn = 1'b0;
  endtask

  // abortAt: 0 none, 1 first cycle, 2 second cycle
  task automatic runAccess(input logic [2:0] m, input logic [1:0] s,
                           input logic [15:0] a, input logic [5:0] d,
                           input logic rd, input logic wr, input int abortAt,
                           input logic holdReq, input logic loadAtT1,
                           input logic [15:0] loadVal);
    @(negedge clk);
    accMode = m; ptrSel = s; directAddr = a; disp = d; rdReq = rd; wrReq = wr;
    @(negedge clk);
    t1Busy = busy; t1Addr = effAddr; t1Sel = {regSel, ioSel, sramSel, outOfRange};
    t1Err = modeErr; t1Off = localOff; t1Strb = {memRd, memWr};
    if (!holdReq) begin rdReq = 1'b0; wrReq = 1'b0; end
    if (abortAt == 1) abortIn = 1'b1;
    if (loadAtT1) begin ptrWrEn = 1'b1; ptrWrSel = s; ptrWrData = loadVal; end
    @(negedge clk);
    ptrWrEn = 1'b0;
    abortIn = (abortAt == 2);
    #0.5;
    t2Busy = busy; t2Rd = memRd; t2Wr = memWr; t2Data = rdData;
    @(negedge clk);
    abortIn = 1'b0;
    n3Busy = busy | memRd | memWr;
    rdReq = 1'b0; wrReq = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; accMode = '0; ptrSel = '0; directAddr = '0; disp = '0;
    rdReq = 1'b0; wrReq = 1'b0; abortIn = 1'b0; ptrWrEn = 1'b0;
    ptrWrSel = '0; ptrWrData = '0;
    regRdData = 8'hA1; ioRdData = 8'hB2; sramRdData = 8'hC3;
    repeat (3) @(negedge clk);
    chk({busy, memRd, memWr, regSel, ioSel, sramSel, outOfRange, modeErr} == 8'h00,
        "R1", "outputs in reset", {busy, memRd, memWr, regSel, ioSel, sramSel, outOfRange, modeErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && memRd == 1'b0 && memWr == 1'b0, "R1", "strobes after reset",
        {busy, memRd, memWr}, 0);
    chk({ptrX, ptrY, ptrZ} == 48'h0, "R1", "pointers after reset", {ptrX ^ ptrY ^ ptrZ}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [3:0] expSel;
      logic [7:0] expData;
      v = VECS[i];
      if (v.sel != 2'd3) loadPtr(v.sel, v.ptrInit);
      runAccess(v.mode, v.sel, v.dAddr, v.dsp, !v.wr, v.wr, 0, 1'b0, 1'b0, 16'h0);
      expSel = 4'b1000 >> v.expReg;
      case (v.expReg)
        2'd0:    expData = 8'hA1;
        2'd1:    expData = 8'hB2;
        2'd2:    expData = 8'hC3;
        default: expData = 8'h00;
      endcase
      chk(t1Busy == 1'b1 && t1Strb == 2'b00, "R10", $sformatf("vec%0d first cycle busy/strobes", i),
          {t1Busy, t1Strb}, 3'b100);
      chk(t1Addr == v.expAddr, modeTag(v.mode), $sformatf("vec%0d address", i), t1Addr, v.expAddr);
      chk(t1Sel == expSel && !t1Err, regTag(v.expReg), $sformatf("vec%0d region", i),
          {t1Err, t1Sel}, expSel);
      chk(t1Off == v.expOff, regTag(v.expReg), $sformatf("vec%0d offset", i), t1Off, v.expOff);
      chk(t2Busy == 1'b0 && t2Rd == (!v.wr && v.expReg != 2'd3) && t2Wr == (v.wr && v.expReg != 2'd3),
          (v.expReg == 2'd3) ? "R9" : "R10", $sformatf("vec%0d second cycle strobes", i),
          {t2Busy, t2Rd, t2Wr}, {1'b0, !v.wr && v.expReg != 2'd3, v.wr && v.expReg != 2'd3});
      if (!v.wr)
        chk(t2Data == expData, (v.expReg == 2'd3) ? "R9" : "R13", $sformatf("vec%0d read data", i),
            t2Data, expData);
      if (v.sel != 2'd3)
        chk(getPtr(v.sel) == v.expPtr, modeTag(v.mode), $sformatf("vec%0d pointer after", i),
            getPtr(v.sel), v.expPtr);
    end

    // R3: X as displacement base
    loadPtr(2'd0, 16'h0030);
    runAccess(3'd2, 2'd0, 16'h0, 6'd5, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0);
    chk(t1Err == 1'b1 && t1Sel == 4'b0000, "R3", "X base mode error", {t1Err, t1Sel}, 5'b10000);
    chk(t2Rd == 1'b0 && t2Wr == 1'b0, "R3", "X base no strobe", {t2Rd, t2Wr}, 0);

    // R3: undefined mode code
    runAccess(3'd6, 2'd1, 16'h0040, 6'd0, 1'b0, 1'b1, 0, 1'b0, 1'b0, 16'h0);
    chk(t1Err == 1'b1 && t2Wr == 1'b0, "R3", "mode 6 error", {t1Err, t2Wr}, 2'b10);

    // R3: pointer select 3 in pre-decrement
    runAccess(3'd3, 2'd3, 16'h0, 6'd0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 16'h0);
    chk(t1Err == 1'b1 && ptrX == 16'h0030, "R3", "select 3 error, X unchanged", ptrX, 16'h0030);

    // R11: abort in first cycle
    loadPtr(2'd2, 16'h0070);
    runAccess(3'd4, 2'd2, 16'h0, 6'd0, 1'b1, 1'b0, 1, 1'b0, 1'b0, 16'h0);
    chk(t2Rd == 1'b0 && t2Busy == 1'b0, "R11", "abort first cycle no strobe", {t2Busy, t2Rd}, 0);
    chk(ptrZ == 16'h0070, "R11", "abort first cycle pointer kept", ptrZ, 16'h0070);

    // R11: abort in second cycle
    loadPtr(2'd1, 16'h0080);
    runAccess(3'd3, 2'd1, 16'h0, 6'd0, 1'b0, 1'b1, 2, 1'b0, 1'b0, 16'h0);
    chk(t2Wr == 1'b0, "R11", "abort second cycle no strobe", t2Wr, 0);
    chk(ptrY == 16'h0080, "R11", "abort second cycle pointer kept", ptrY, 16'h0080);

    // R12: load during access ignored, load while idle applied
    loadPtr(2'd0, 16'h0050);
    chk(ptrX == 16'h0050, "R12", "idle load applied", ptrX, 16'h0050);
    runAccess(3'd1, 2'd0, 16'h0, 6'd0, 1'b1, 1'b0, 0, 1'b0, 1'b1, 16'h1234);
    chk(ptrX == 16'h0050, "R12", "load during access ignored", ptrX, 16'h0050);

    // R10: read and write together is a read
    runAccess(3'd0, 2'd3, 16'h0070, 6'd0, 1'b1, 1'b1, 0, 1'b0, 1'b0, 16'h0);
    chk(t2Rd == 1'b1 && t2Wr == 1'b0, "R10", "read wins", {t2Rd, t2Wr}, 2'b10);

    // R10: request held through the access is not retaken during it
    runAccess(3'd0, 2'd3, 16'h0010, 6'd0, 1'b1, 1'b0, 0, 1'b1, 1'b0, 16'h0);
    chk(t2Rd == 1'b1, "R10", "held request strobe", t2Rd, 1);
    chk(n3Busy == 1'b0, "R10", "idle after second cycle", n3Busy, 0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule